// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit sits beside the receive, transmit and modem-control logic of a PC-style serial port. It keeps one pending flag for each of the port's four interrupt causes: line error, received data, transmitter empty and modem input change. It also keeps the interrupt-enable mask written by software. From these it forms the identification byte that software reads to find out why the port interrupted, and the interrupt line that goes to the system interrupt controller.

Neighbouring logic raises a cause with a one-cycle set pulse. The unit clears each cause as a side effect of the register read that software uses to service it. It also holds the sticky line-error bits and modem-delta bits, because reading their status registers clears them too. The identification byte is recomputed combinationally from the registered flags, so it follows any change of flags or mask with no added latency.

Top module: `uart_int_ident`

## Requirements
- R1: When several enabled causes are pending, the reported cause follows a fixed priority: line error first, then received data, then transmitter empty, then modem change. Enable bits: bit 0 received data, bit 1 transmitter empty, bit 2 line error, bit 3 modem change.
- R2: Bits 3:0 of `iir` are 0x6 for line error, 0x4 for received data, 0x2 for transmitter empty, 0x0 for modem change, and 0x1 when no enabled cause is pending. Bits 5:4 always read 0.
- R3: When `fifo_en` is high, bits 7:6 of `iir` read 11. Otherwise they read 00.
- R4: `irq` is high only while an enabled cause is pending and `out2` is high.
- R5: A pulse on `rd_iir` clears the transmitter-empty flag only if `iir` reports transmitter empty in that cycle. Otherwise the flag is kept.
- R6: A pulse on `rd_lsr` clears the line-error flag and all four `lsr_err` bits. These bits are set per bit by `line_err_set`, and any set bit also raises the line-error flag.
- R7: A pulse on `rd_msr` clears the four `msr_delta` bits and the modem flag. These bits are set per bit by `modem_delta_set`, and any set bit also raises the modem flag.
- R8: A pulse on `rd_rbr` clears the received-data flag only when `rx_drained` is high in the same cycle.
- R9: A write to the enable register stores only bits 3:0 of `ier_wdata`. These bits are visible on `ier_q` after the write edge.
- R10: A disabled cause stays pending without affecting `iir` or `irq`, and it appears as soon as its enable bit is set.
- R11: If a set pulse and a clearing read reach the same flag in the same cycle, the flag ends set.
- R12: After reset, `iir` reads 0x01, and `irq`, `ier_q`, `lsr_err` and `msr_delta` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_we | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| ier_q | output | 4 | Stored enable mask |
| fifo_en | input | 1 | FIFO mode active (from FIFO control) |
| out2 | input | 1 | Interrupt-line gate bit from modem control |
| line_err_set | input | 4 | Line-error bit set pulses |
| rx_ready_set | input | 1 | Received-data-available set pulse |
| rx_drained | input | 1 | Receive buffer empty after the current data read |
| thr_empty_set | input | 1 | Transmitter-empty set pulse |
| modem_delta_set | input | 4 | Modem-delta bit set pulses |
| rd_rbr | input | 1 | Data register read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request line |
| lsr_err | output | 4 | Sticky line-error bits |
| msr_delta | output | 4 | Sticky modem-delta bits |

## Verification
The priority encoder is driven with every mixture of pending causes that separates each rank from the ones below it. These include all four causes at once, each cause alone, and masks that hide the highest pending cause, so a wrong rank or a wrong code shows up as a different identification byte. The same vectors vary `out2` and `fifo_en` on their own, which separates the line gating and the top-bits rule from the cause selection. Directed sequences then service each cause through its own read. Each read is done both when it should clear the flag and when it must leave the flag alone, and the bench also checks a set pulse that arrives in the same cycle as the clearing read.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;

   localparam int NSRC = 4;

   // index values equal the enable-register bit of each cause
   typedef enum logic [1:0] {
      SRC_RXD   = 2'd0,
      SRC_THRE  = 2'd1,
      SRC_LINE  = 2'd2,
      SRC_MODEM = 2'd3
   } src_e;

   // rank 0 is the most urgent cause
   function automatic src_e rank_src(input int rank);
      case (rank)
         0:       return SRC_LINE;
         1:       return SRC_RXD;
         2:       return SRC_THRE;
         default: return SRC_MODEM;
      endcase
   endfunction

   // cause code placed in bits 3:1 of the identification byte
   function automatic logic [2:0] id_code(input src_e s);
      case (s)
         SRC_LINE:  return 3'b011;
         SRC_RXD:   return 3'b010;
         SRC_THRE:  return 3'b001;
         default:   return 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/uart_int_flags.sv
module uart_int_flags #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("uart_int_flags: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            q_o[i] <= 1'b0;
         else if (set_i[i])
            q_o[i] <= 1'b1;          // a new event beats a clearing read
         else if (clr_i[i])
            q_o[i] <= 1'b0;
      end
   end

   a_r11_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
   import uart_int_pkg::*;
(
   input  logic [NSRC-1:0] req_i,
   output logic            hit_o,
   output src_e            win_o
);

   always_comb begin
      hit_o = 1'b0;
      win_o = SRC_MODEM;
      for (int r = NSRC - 1; r >= 0; r--) begin
         if (req_i[int'(rank_src(r))]) begin
            hit_o = 1'b1;
            win_o = rank_src(r);
         end
      end
   end

   always_comb begin
      if (req_i[SRC_LINE])
         a_r1_line_first : assert (hit_o && win_o == SRC_LINE);
      if (hit_o && win_o == SRC_MODEM)
         a_r1_modem_last : assert (req_i[2:0] == 3'b000);
      a_r2_hit_any : assert (hit_o == (|req_i));
   end

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
   import uart_int_pkg::*;
#(
   parameter int REG_W         = 8,
   parameter int ERR_W         = 4,
   parameter int DLT_W         = 4,
   parameter bit FIFO_CAPABLE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ier_we,
   input  logic [REG_W-1:0] ier_wdata,
   output logic [NSRC-1:0]  ier_q,
   input  logic             fifo_en,
   input  logic             out2,
   input  logic [ERR_W-1:0] line_err_set,
   input  logic             rx_ready_set,
   input  logic             rx_drained,
   input  logic             thr_empty_set,
   input  logic [DLT_W-1:0] modem_delta_set,
   input  logic             rd_rbr,
   input  logic             rd_iir,
   input  logic             rd_lsr,
   input  logic             rd_msr,
   output logic [REG_W-1:0] iir,
   output logic             irq,
   output logic [ERR_W-1:0] lsr_err,
   output logic [DLT_W-1:0] msr_delta
);

   localparam int PAD_W = REG_W - 6;

   if (REG_W < 8) begin : g_bad_reg
      $error("uart_int_ident: REG_W must be at least 8");
   end
   if (NSRC > REG_W) begin : g_bad_src
      $error("uart_int_ident: enable mask wider than register");
   end

   // ---------------- enable mask ----------------
   always_ff @(posedge clk) begin
      if (!rst_n)
         ier_q <= '0;
      else if (ier_we)
         ier_q <= ier_wdata[NSRC-1:0];
   end

   a_r9_ier_low_bits : assert property (@(posedge clk) disable iff (!rst_n)
      ier_we |=> ier_q == $past(ier_wdata[NSRC-1:0]));

   // ---------------- priority ----------------
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] active;
   logic            hit;
   src_e            win;

   assign active = pend & ier_q;

   uart_int_prio u_prio (
      .req_i (active),
      .hit_o (hit),
      .win_o (win)
   );

   // ---------------- pending flags ----------------
   logic [NSRC-1:0] src_set;
   logic [NSRC-1:0] src_clr;
   logic            thre_shown;

   assign thre_shown = hit && (win == SRC_THRE);

   always_comb begin
      src_set             = '0;
      src_set[SRC_RXD]    = rx_ready_set;
      src_set[SRC_THRE]   = thr_empty_set;
      src_set[SRC_LINE]   = |line_err_set;
      src_set[SRC_MODEM]  = |modem_delta_set;
      src_clr             = '0;
      src_clr[SRC_RXD]    = rd_rbr && rx_drained;
      src_clr[SRC_THRE]   = rd_iir && thre_shown;
      src_clr[SRC_LINE]   = rd_lsr;
      src_clr[SRC_MODEM]  = rd_msr;
   end

   uart_int_flags #(.W(NSRC)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_set),
      .clr_i (src_clr),
      .q_o   (pend)
   );

   // ---------------- sticky status bits ----------------
   uart_int_flags #(.W(ERR_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (line_err_set),
      .clr_i ({ERR_W{rd_lsr}}),
      .q_o   (lsr_err)
   );

   uart_int_flags #(.W(DLT_W)) u_dlt (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (modem_delta_set),
      .clr_i ({DLT_W{rd_msr}}),
      .q_o   (msr_delta)
   );

   // ---------------- identification byte ----------------
   logic [1:0] top_bits;
   logic [3:0] low_nib;

   if (FIFO_CAPABLE) begin : g_fifo
      assign top_bits = fifo_en ? 2'b11 : 2'b00;
   end else begin : g_nofifo
      assign top_bits = 2'b00;
   end

   assign low_nib = hit ? {id_code(win), 1'b0} : 4'b0001;
   assign iir     = {top_bits, {PAD_W{1'b0}}, low_nib};
   assign irq     = hit && out2;

   a_r4_irq_gated : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (out2 && (|(pend & ier_q))));

   a_r5_thre_read : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_iir && iir[3:0] == 4'h2 && !thr_empty_set) |=> !pend[SRC_THRE]);

   a_r5_thre_keep : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_iir && iir[3:0] != 4'h2 && pend[SRC_THRE]) |=> pend[SRC_THRE]);

   a_r6_lsr_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lsr && line_err_set == '0) |=> (lsr_err == '0 && !pend[SRC_LINE]));

   a_r7_msr_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_msr && modem_delta_set == '0) |=> (msr_delta == '0 && !pend[SRC_MODEM]));

   a_r8_rx_keep : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rbr && !rx_drained && pend[SRC_RXD]) |=> pend[SRC_RXD]);

   a_r2_none_code : assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ier_q) == '0) |-> (iir[3:0] == 4'h1 && !irq));

endmodule

// File: tb/tb_uart_int_ident.sv
`timescale 1ns/1ps
module tb_uart_int_ident;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ier_we;
   logic [7:0] ier_wdata;
   logic [3:0] ier_q;
   logic       fifo_en, out2;
   logic [3:0] line_err_set;
   logic       rx_ready_set, rx_drained, thr_empty_set;
   logic [3:0] modem_delta_set;
   logic       rd_rbr, rd_iir, rd_lsr, rd_msr;
   logic [7:0] iir;
   logic       irq;
   logic [3:0] lsr_err, msr_delta;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   uart_int_ident dut (
      .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
      .ier_q(ier_q), .fifo_en(fifo_en), .out2(out2),
      .line_err_set(line_err_set), .rx_ready_set(rx_ready_set),
      .rx_drained(rx_drained), .thr_empty_set(thr_empty_set),
      .modem_delta_set(modem_delta_set), .rd_rbr(rd_rbr), .rd_iir(rd_iir),
      .rd_lsr(rd_lsr), .rd_msr(rd_msr), .iir(iir), .irq(irq),
      .lsr_err(lsr_err), .msr_delta(msr_delta)
   );

   // {ier[3:0], set mask {modem,line,thre,rxd}, out2, fifo_en, iir[7:0], irq}
   localparam int NV = 12;
   localparam logic [18:0] VEC [NV] = '{
      {4'hF, 4'hF, 1'b1, 1'b0, 8'h06, 1'b1},
      {4'hF, 4'hB, 1'b1, 1'b0, 8'h04, 1'b1},
      {4'hF, 4'hA, 1'b1, 1'b0, 8'h02, 1'b1},
      {4'hF, 4'h8, 1'b1, 1'b0, 8'h00, 1'b1},
      {4'hF, 4'h0, 1'b1, 1'b0, 8'h01, 1'b0},
      {4'hB, 4'hF, 1'b1, 1'b0, 8'h04, 1'b1},
      {4'h8, 4'hF, 1'b1, 1'b1, 8'hC0, 1'b1},
      {4'h2, 4'hF, 1'b0, 1'b1, 8'hC2, 1'b0},
      {4'h0, 4'hF, 1'b1, 1'b0, 8'h01, 1'b0},
      {4'h4, 4'h4, 1'b0, 1'b0, 8'h06, 1'b0},
      {4'h3, 4'hC, 1'b1, 1'b1, 8'hC1, 1'b0},
      {4'h6, 4'h3, 1'b1, 1'b0, 8'h02, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ier_we = 0; line_err_set = 0; rx_ready_set = 0; rx_drained = 0;
      thr_empty_set = 0; modem_delta_set = 0;
      rd_rbr = 0; rd_iir = 0; rd_lsr = 0; rd_msr = 0;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      step(); step();
      rst_n = 1;
   endtask

   task automatic wr_ier(input logic [7:0] v);
      ier_we = 1; ier_wdata = v; step(); ier_we = 0;
   endtask

   initial begin
      fifo_en = 0; out2 = 0; ier_wdata = 0;
      @(negedge clk);
      do_reset();

      // R12 reset state
      chk("R12 iir", iir, 8'h01);
      chk("R12 irq", {7'd0, irq}, 8'h00);
      chk("R12 ier", {4'd0, ier_q}, 8'h00);
      chk("R12 err", {4'd0, lsr_err}, 8'h00);
      chk("R12 dlt", {4'd0, msr_delta}, 8'h00);

      // R1 R2 R3 R4 R10 vector walk
      for (int i = 0; i < NV; i++) begin
         do_reset();
         wr_ier({4'h0, VEC[i][18:15]});
         out2    = VEC[i][10];
         fifo_en = VEC[i][9];
         rx_ready_set    = VEC[i][11];
         thr_empty_set   = VEC[i][12];
         line_err_set    = {3'b000, VEC[i][13]};
         modem_delta_set = {3'b000, VEC[i][14]};
         step();
         idle();
         chk($sformatf("R1 R2 R3 vec%0d iir", i), iir, VEC[i][8:1]);
         chk($sformatf("R4 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
      end

      // R9 only low nibble stored
      do_reset(); fifo_en = 0; out2 = 1;
      wr_ier(8'hFF); chk("R9 ier FF", {4'd0, ier_q}, 8'h0F);
      wr_ier(8'hA5); chk("R9 ier A5", {4'd0, ier_q}, 8'h05);

      // R5 transmitter-empty read clear
      wr_ier(8'h0F);
      thr_empty_set = 1; step(); idle();
      chk("R5 thre shown", iir, 8'h02);
      rd_iir = 1; step(); idle();
      chk("R5 thre cleared", iir, 8'h01);
      thr_empty_set = 1; rx_ready_set = 1; step(); idle();
      chk("R5 rx over thre", iir, 8'h04);
      rd_iir = 1; step(); idle();
      rd_rbr = 1; rx_drained = 1; step(); idle();
      chk("R5 thre kept", iir, 8'h02);
      rd_iir = 1; step(); idle();

      // R8 data read clears only when drained
      rx_ready_set = 1; step(); idle();
      rd_rbr = 1; rx_drained = 0; step(); idle();
      chk("R8 not drained", iir, 8'h04);
      rd_rbr = 1; rx_drained = 1; step(); idle();
      chk("R8 drained", iir, 8'h01);

      // R11 set and clear together
      rx_ready_set = 1; step(); idle();
      rx_ready_set = 1; rd_rbr = 1; rx_drained = 1; step(); idle();
      chk("R11 set wins", iir, 8'h04);
      rd_rbr = 1; rx_drained = 1; step(); idle();

      // R6 line status read
      line_err_set = 4'b1010; step(); idle();
      chk("R6 err bits", {4'd0, lsr_err}, 8'h0A);
      chk("R6 line shown", iir, 8'h06);
      rd_lsr = 1; step(); idle();
      chk("R6 err cleared", {4'd0, lsr_err}, 8'h00);
      chk("R6 line cleared", iir, 8'h01);

      // R7 modem status read
      modem_delta_set = 4'b0101; step(); idle();
      chk("R7 delta bits", {4'd0, msr_delta}, 8'h05);
      chk("R7 modem shown", iir, 8'h00);
      rd_msr = 1; step(); idle();
      chk("R7 delta cleared", {4'd0, msr_delta}, 8'h00);
      chk("R7 modem cleared", iir, 8'h01);

      // R10 hidden cause appears on enable
      wr_ier(8'h00);
      modem_delta_set = 4'b0001; step(); idle();
      chk("R10 hidden iir", iir, 8'h01);
      chk("R10 hidden irq", {7'd0, irq}, 8'h00);
      wr_ier(8'h08);
      chk("R10 shown iir", iir, 8'h00);
      chk("R10 shown irq", {7'd0, irq}, 8'h01);

      // R4 gate drop, R3 fifo toggle
      out2 = 0; step();
      chk("R4 out2 low", {7'd0, irq}, 8'h00);
      fifo_en = 1; step();
      chk("R3 fifo top", iir, 8'hC0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule